// File: doc/BRIEF.md
# Two-Write Platform Reset Sequencer

This block watches a stream of single-cycle register writes and turns a two-step write sequence into timed reset pulses for the local card. The first write of a sequence arms the block. Only a matching second write fires the reset. Any stray write between the two discards the armed state.

An I/O write to port 0xCF9 arms or fires a hard reset or a soft reset. A hard reset asserts CPU reset, the active-low PCI reset and the ISA reset drive together. A soft reset pulses only the CPU INIT line.

Some agents can issue memory writes but cannot issue I/O writes. For them, the same hard reset can be requested by writing to two fixed memory addresses. The block drives nothing that would reset an attached switch fabric: every output acts on the local card only.

Top module: `rstseq_top`

## Requirements
- R1: After reset, the outputs are idle: cpuReset=0, pciResetN=1, isaResetDrv=0 and cpuInit=0.
- R2: An I/O write (wrIsIo=1) of exactly 0x02 to address 0xCF9 arms a hard reset. This write alone changes no output. A following I/O write of exactly 0x06 to 0xCF9 sets cpuReset=1, pciResetN=0 and isaResetDrv=1, starting the cycle after that write is sampled.
- R3: An I/O write of exactly 0x00 to 0xCF9 followed by an I/O write of exactly 0x04 to 0xCF9 raises cpuInit for exactly INIT_CYCLES cycles (4 by default). The three hard-reset outputs stay idle.
- R4: A firing write (0x06 or 0x04 to 0xCF9) that is not preceded by its matching arming write has no effect.
- R5: While armed, any write that is neither a new arming write nor the matching firing write discards the armed state. Examples are another address, another value, or the firing value of the other mode. A later firing write then has no effect.
- R6: A memory write (wrIsIo=0) of 0x02 to 0xFFFFFFF0 followed by a memory write of 0x06 to 0xFFFFFFF4 causes the same hard reset as R2. An arm on one path followed by a fire on the other path has no effect.
- R7: The I/O-versus-memory flag is part of the decode. A memory write to 0xCF9, or an I/O write to either alias address, is not a sequence write.
- R8: The hard-reset outputs stay asserted for exactly HARD_CYCLES cycles (16 by default), all three together, and then deassert together.
- R9: Writes that arrive while a pulse is active are ignored. When the pulse ends, the block is idle and unarmed, so a firing write needs a fresh arming write.
- R10: cpuInit and cpuReset are never asserted in the same cycle.
- R11: An arming write that arrives while the block is armed replaces the armed mode with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | One write is presented this cycle |
| wrIsIo | input | 1 | 1 = I/O space write, 0 = memory write |
| wrAddr | input | 32 | Write address |
| wrData | input | 8 | Write data byte |
| cpuReset | output | 1 | CPU hard reset, active high |
| pciResetN | output | 1 | PCI reset, active low |
| isaResetDrv | output | 1 | ISA reset drive, active high |
| cpuInit | output | 1 | CPU INIT pulse, active high |

## Verification
The assertions assume that each write lasts exactly one cycle with wrValid high, and that the address, data and space flag are stable whenever wrValid is high. They also assume that the reset outputs only rise as a consequence of a write sampled in the previous cycle. The bench issues each write from a task that holds wrValid for a single clock and drives every input on the falling edge. It then waits for each pulse to end before starting a new sequence, except in the scenario that deliberately writes during a pulse.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    W_NONE,
    W_IO_ARM_HARD,
    W_IO_ARM_SOFT,
    W_IO_GO_HARD,
    W_IO_GO_SOFT,
    W_MEM_ARM,
    W_MEM_GO,
    W_OTHER
  } wr_class_e;

  typedef struct packed {
    logic loadHard;
    logic loadSoft;
  } pulse_strobe_t;

endpackage

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] IO_PORT_ADDR = 'h0CF9,
  parameter logic [ADDR_W-1:0] ALIAS_ARM_ADDR = 'hFFFF_FFF0,
  parameter logic [ADDR_W-1:0] ALIAS_GO_ADDR = 'hFFFF_FFF4,
  parameter int HARD_CYCLES = 16,
  parameter int INIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              wrIsIo,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  pulse_strobe_t     strobe,
  output wr_class_e         wrClass,
  output logic              pulseLast,
  output logic              hardOn,
  output logic              initOn
);

  localparam int MODE_BIT = 1;
  localparam int GO_BIT = 2;
  localparam int MAX_CYC = (HARD_CYCLES > INIT_CYCLES) ? HARD_CYCLES : INIT_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [DATA_W-1:0] ARM_HARD_VAL = DATA_W'(1) << MODE_BIT;
  localparam logic [DATA_W-1:0] ARM_SOFT_VAL = '0;
  localparam logic [DATA_W-1:0] GO_HARD_VAL = ARM_HARD_VAL | (DATA_W'(1) << GO_BIT);
  localparam logic [DATA_W-1:0] GO_SOFT_VAL = ARM_SOFT_VAL | (DATA_W'(1) << GO_BIT);
  localparam logic [CNT_W-1:0] HARD_LOAD = CNT_W'(HARD_CYCLES - 1);
  localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_CYCLES - 1);

  logic ioHit, memArmHit, memGoHit;
  logic [CNT_W-1:0] remain;

  assign ioHit     = wrIsIo && (wrAddr == IO_PORT_ADDR);
  assign memArmHit = !wrIsIo && (wrAddr == ALIAS_ARM_ADDR);
  assign memGoHit  = !wrIsIo && (wrAddr == ALIAS_GO_ADDR);

  always_comb begin
    wrClass = W_OTHER;
    if (!wrValid)                               wrClass = W_NONE;
    else if (ioHit && wrData == ARM_HARD_VAL)   wrClass = W_IO_ARM_HARD;
    else if (ioHit && wrData == ARM_SOFT_VAL)   wrClass = W_IO_ARM_SOFT;
    else if (ioHit && wrData == GO_HARD_VAL)    wrClass = W_IO_GO_HARD;
    else if (ioHit && wrData == GO_SOFT_VAL)    wrClass = W_IO_GO_SOFT;
    else if (memArmHit && wrData == ARM_HARD_VAL) wrClass = W_MEM_ARM;
    else if (memGoHit && wrData == GO_HARD_VAL)   wrClass = W_MEM_GO;
  end

  assign pulseLast = (hardOn || initOn) && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      hardOn <= 1'b0;
      initOn <= 1'b0;
    end else if (strobe.loadHard) begin
      remain <= HARD_LOAD;
      hardOn <= 1'b1;
      initOn <= 1'b0;
    end else if (strobe.loadSoft) begin
      remain <= INIT_LOAD;
      hardOn <= 1'b0;
      initOn <= 1'b1;
    end else if (pulseLast) begin
      hardOn <= 1'b0;
      initOn <= 1'b0;
    end else if (hardOn || initOn) begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  wr_class_e     wrClass,
  input  logic          pulseLast,
  output pulse_strobe_t strobe
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM_IO_HARD,
    S_ARM_IO_SOFT,
    S_ARM_MEM,
    S_BUSY
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe = '0;
    if (state == S_BUSY) begin
      if (pulseLast) stateNext = S_IDLE;
    end else begin
      case (wrClass)
        W_NONE:        stateNext = state;
        W_IO_ARM_HARD: stateNext = S_ARM_IO_HARD;
        W_IO_ARM_SOFT: stateNext = S_ARM_IO_SOFT;
        W_MEM_ARM:     stateNext = S_ARM_MEM;
        W_IO_GO_HARD: begin
          stateNext = (state == S_ARM_IO_HARD) ? S_BUSY : S_IDLE;
          strobe.loadHard = (state == S_ARM_IO_HARD);
        end
        W_IO_GO_SOFT: begin
          stateNext = (state == S_ARM_IO_SOFT) ? S_BUSY : S_IDLE;
          strobe.loadSoft = (state == S_ARM_IO_SOFT);
        end
        W_MEM_GO: begin
          stateNext = (state == S_ARM_MEM) ? S_BUSY : S_IDLE;
          strobe.loadHard = (state == S_ARM_MEM);
        end
        default:       stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int HARD_CYCLES = 16,
  parameter int INIT_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        wrIsIo,
  input  logic [31:0] wrAddr,
  input  logic [7:0]  wrData,
  output logic        cpuReset,
  output logic        pciResetN,
  output logic        isaResetDrv,
  output logic        cpuInit
);

  pulse_strobe_t strobe;
  wr_class_e     wrClass;
  logic          pulseLast;
  logic          hardOn;
  logic          initOn;

  rstseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrClass   (wrClass),
    .pulseLast (pulseLast),
    .strobe    (strobe)
  );

  rstseq_datapath #(
    .ADDR_W      (32),
    .DATA_W      (8),
    .HARD_CYCLES (HARD_CYCLES),
    .INIT_CYCLES (INIT_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .wrIsIo    (wrIsIo),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .wrClass   (wrClass),
    .pulseLast (pulseLast),
    .hardOn    (hardOn),
    .initOn    (initOn)
  );

  assign cpuReset    = hardOn;
  assign pciResetN   = !hardOn;
  assign isaResetDrv = hardOn;
  assign cpuInit     = initOn;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int HARD_CYCLES = 16,
  parameter int INIT_CYCLES = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic       wrIsIo,
  input logic [7:0] wrData,
  input logic       cpuReset,
  input logic       pciResetN,
  input logic       isaResetDrv,
  input logic       cpuInit
);

  int hardLen;
  int initLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hardLen <= 0;
      initLen <= 0;
    end else begin
      hardLen <= !pciResetN ? hardLen + 1 : 0;
      initLen <= cpuInit ? initLen + 1 : 0;
    end
  end

  // R1: outputs idle in the first cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!cpuReset && pciResetN && !isaResetDrv && !cpuInit));

  // R2: a hard pulse only starts after a firing write of 0x06
  a_r2_hard_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuReset) |-> $past(wrValid && wrData == 8'h06));

  // R3: INIT pulse follows an I/O write of 0x04
  a_r3_init_needs_io_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuInit) |-> $past(wrValid && wrIsIo && wrData == 8'h04));

  // R3: INIT pulse length
  a_r3_init_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuInit) |-> (initLen == INIT_CYCLES));

  // R8: hard pulse length and lockstep of the three lines
  a_r8_hard_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuReset) |-> (hardLen == HARD_CYCLES));

  a_r8_hard_lockstep: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReset == isaResetDrv) && (cpuReset == !pciResetN));

  // R10: INIT and CPU reset exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cpuReset, cpuInit}));

endmodule

bind rstseq_top rstseq_chk #(
  .HARD_CYCLES (HARD_CYCLES),
  .INIT_CYCLES (INIT_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrValid     (wrValid),
  .wrIsIo      (wrIsIo),
  .wrData      (wrData),
  .cpuReset    (cpuReset),
  .pciResetN   (pciResetN),
  .isaResetDrv (isaResetDrv),
  .cpuInit     (cpuInit)
);

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HARD_CYC = 16;
  localparam int INIT_CYC = 4;
  localparam logic [31:0] PORT = 32'h0000_0CF9;
  localparam logic [31:0] ALIAS_A = 32'hFFFF_FFF0;
  localparam logic [31:0] ALIAS_B = 32'hFFFF_FFF4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic wrIsIo = 1'b0;
  logic [31:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic cpuReset, pciResetN, isaResetDrv, cpuInit;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstseq_top #(.HARD_CYCLES(HARD_CYC), .INIT_CYCLES(INIT_CYC)) u_dut (
    .clk (clk), .rstN (rstN), .wrValid (wrValid), .wrIsIo (wrIsIo),
    .wrAddr (wrAddr), .wrData (wrData), .cpuReset (cpuReset),
    .pciResetN (pciResetN), .isaResetDrv (isaResetDrv), .cpuInit (cpuInit)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic io, input logic [31:0] a, input logic [7:0] d);
    wrValid = 1'b1; wrIsIo = io; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0; wrIsIo = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  function automatic int idleCode();
    return {cpuReset, !pciResetN, isaResetDrv, cpuInit};
  endfunction

  task automatic idleWait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts cycles the hard outputs stay asserted, current cycle included
  task automatic hardLen(output int n);
    n = 0;
    while (!pciResetN && n < 100) begin
      if (!(cpuReset && isaResetDrv)) n = 1000;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic initLen(output int n);
    n = 0;
    while (cpuInit && n < 100) begin
      if (cpuReset) n = 1000;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic tReset();
    check("R1 cpuReset", cpuReset, 0);
    check("R1 pciResetN", pciResetN, 1);
    check("R1 isaResetDrv", isaResetDrv, 0);
    check("R1 cpuInit", cpuInit, 0);
  endtask

  task automatic tIoHard();
    int n;
    wr(1, PORT, 8'h02);
    check("R2 arm alone idle", idleCode(), 0);
    wr(1, PORT, 8'h06);
    check("R2 hard outputs", idleCode(), 4'b1110);
    hardLen(n);
    check("R8 hard length", n, HARD_CYC);
    check("R8 idle after", idleCode(), 0);
  endtask

  task automatic tSoft();
    int n;
    wr(1, PORT, 8'h00);
    wr(1, PORT, 8'h04);
    check("R3 init only", idleCode(), 4'b0001);
    check("R10 no cpuReset during init", cpuReset, 0);
    initLen(n);
    check("R3 init length", n, INIT_CYC);
  endtask

  task automatic tNoArm();
    wr(1, PORT, 8'h06);
    check("R4 hard fire unarmed", idleCode(), 0);
    wr(1, PORT, 8'h04);
    check("R4 soft fire unarmed", idleCode(), 0);
  endtask

  task automatic tCancel();
    wr(1, PORT, 8'h02); wr(1, 32'h80, 8'h00); wr(1, PORT, 8'h06);
    check("R5 cancel by address", idleCode(), 0);
    wr(1, PORT, 8'h02); wr(1, PORT, 8'h04);
    check("R5 mismatched fire", idleCode(), 0);
    wr(1, PORT, 8'h06);
    check("R5 disarmed after mismatch", idleCode(), 0);
    wr(1, PORT, 8'h02); wr(1, PORT, 8'h42); wr(1, PORT, 8'h06);
    check("R5 cancel by value", idleCode(), 0);
  endtask

  task automatic tRearm();
    int n;
    wr(1, PORT, 8'h02); wr(1, PORT, 8'h00); wr(1, PORT, 8'h04);
    check("R11 rearm to soft", idleCode(), 4'b0001);
    initLen(n);
    wr(1, PORT, 8'h00); wr(1, PORT, 8'h02); wr(1, PORT, 8'h06);
    check("R11 rearm to hard", idleCode(), 4'b1110);
    hardLen(n);
    check("R11 hard length", n, HARD_CYC);
  endtask

  task automatic tMem();
    int n;
    wr(0, ALIAS_A, 8'h02);
    check("R6 alias arm idle", idleCode(), 0);
    wr(0, ALIAS_B, 8'h06);
    check("R6 alias hard", idleCode(), 4'b1110);
    check("R10 no init during hard", cpuInit, 0);
    hardLen(n);
    check("R6 alias length", n, HARD_CYC);
    wr(0, ALIAS_A, 8'h02); wr(1, PORT, 8'h06);
    check("R6 mem arm io fire", idleCode(), 0);
    wr(1, PORT, 8'h02); wr(0, ALIAS_B, 8'h06);
    check("R6 io arm mem fire", idleCode(), 0);
  endtask

  task automatic tSpace();
    wr(1, ALIAS_A, 8'h02); wr(1, ALIAS_B, 8'h06);
    check("R7 io at alias", idleCode(), 0);
    wr(0, PORT, 8'h02); wr(0, PORT, 8'h06);
    check("R7 mem at port", idleCode(), 0);
  endtask

  task automatic tBusy();
    int n;
    wr(1, PORT, 8'h02); wr(1, PORT, 8'h06);
    wr(1, PORT, 8'h02);
    hardLen(n);
    check("R9 length with writes", n + 1, HARD_CYC);
    wr(1, PORT, 8'h06);
    check("R9 arm during pulse ignored", idleCode(), 0);
    wr(1, PORT, 8'h02); wr(1, PORT, 8'h06);
    hardLen(n);
    wr(1, PORT, 8'h06);
    check("R9 unarmed after pulse", idleCode(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    idleWait(3);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tIoHard();
    tSoft();
    tNoArm();
    tCancel();
    tRearm();
    tMem();
    tSpace();
    tBusy();
    idleWait(2);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule